// File: doc/BRIEF.md
# Cascaded Wide Counter and Programmable Divider

This block builds one wide synchronous counter, 32 bits by default, from a row of identical narrow counter slices on a single clock. Each slice has an active-low enable, a parallel-load enable and an active-low flag that goes low when the slice holds all ones.

The slices are chained through their flags. The lowest slice always steps. The second slice is enabled straight from the lowest slice's flag. Every slice above that is enabled by the OR of the flags of all slices below it. A slice therefore advances only on the edge where every lower slice rolls from all ones back to zero.

The block has two modes. In count mode the chain runs freely and wraps. In divider mode a gating stage watches all the flags. When every slice holds all ones, it drives the load enable of every slice at once, so the chain divides the clock by M when the preset word is 2^N − M. Each slice's own reload-at-top path is tied off, because a single slice cannot know when the whole chain has reached its top value. A global load input copies the preset word into the chain in either mode.

Top module: `cascade_counter`

## Requirements
- R1: While reset is high, and at the first sample after it is released, `count` is 0 and `chain_tc_n` is 1.
- R2: In count mode with `load` low, `count` rises by exactly one on every clock edge and wraps from all ones to 0.
- R3: A slice above the lowest one changes only on an edge where every lower slice holds all ones; on that edge every lower slice returns to zero.
- R4: `chain_tc_n` is 0 in exactly those cycles in which all N bits of `count` are one.
- R5: When `load` is high at an edge, `count` equals the `preset` value present at that edge, in either mode.
- R6: In divider mode (`div_mode` = 1), the edge after `count` reaches all ones loads `preset`, so `chain_tc_n` goes low once every M cycles, where M = 2^N − `preset`, for any M from 1 to 2^N.
- R7: In count mode `preset` has no effect unless `load` is high; changing it while counting leaves the count sequence unchanged.
- R8: If `load` is high in the same cycle that a carry would ripple into upper slices, the load wins and no slice takes its counted value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for all slices |
| rst | input | 1 | Asynchronous reset, active high |
| div_mode | input | 1 | 1 selects divider mode (reload at full-chain terminal count), 0 selects free counting |
| load | input | 1 | Global synchronous load of the preset word |
| preset | input | WIDTH | Preset word; for divide ratio M use 2^WIDTH − M |
| count | output | WIDTH | Concatenated slice values, lowest slice in the low bits |
| chain_tc_n | output | 1 | Active-low chain terminal count, low when `count` is all ones |

## Verification
Two events can fall in the same cycle: a global load and a carry ripple through the slices. In divider mode a third can join them, the terminal-count reload. The bench first parks the chain one step below a multi-slice rollover (0x00FFFFFF). It then raises `load` with an unrelated preset in that same cycle and expects the preset on the next edge, not 0x01000000. A second case loads a new preset exactly at terminal count while the divider runs, and judges that the new word, not the old one, arrives.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;

  localparam int DEF_SLICE_W = 8;
  localparam int DEF_SLICES  = 4;

  // preset word that makes a chain of width w divide by ratio m
  function automatic logic [63:0] ratio_to_preset(input int unsigned w, input logic [63:0] m);
    logic [64:0] full;
    full = 65'd1 << w;
    return 64'(full - {1'b0, m});
  endfunction

  // a slice value is at its top when every bit is one
  function automatic logic slice_at_top(input logic [63:0] v, input int unsigned w);
    logic [63:0] mask;
    mask = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    return (v & mask) == mask;
  endfunction

endpackage

// File: rtl/cc_slice.sv
module cc_slice #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          pe,
  input  logic          self_reload,
  input  logic [SW-1:0] p,
  output logic [SW-1:0] q,
  output logic          tc_n
);
  import cascade_counter_pkg::*;

  logic [SW-1:0] q_r;
  logic          at_top;
  logic          take_load;
  logic          take_step;

  assign at_top    = slice_at_top(64'(q_r), SW);
  assign tc_n      = ~at_top;
  // own reload path exists but is tied off when slices are chained
  assign take_load = pe | (~ce_n & self_reload & at_top);
  assign take_step = ~ce_n & ~take_load;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)            q_r <= '0;
    else if (take_load) q_r <= p;
    else if (take_step) q_r <= q_r + 1'b1;
  end

  assign q = q_r;

  AST_SLICE_LOAD: assert property (@(posedge clk) disable iff (rst)
    pe |=> (q == $past(p)));                                   // R5
  AST_SLICE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pe && ce_n) |=> $stable(q));                             // R3
  AST_SLICE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!pe && !ce_n && !self_reload && at_top) |=> (q == '0));   // R3

endmodule

// File: rtl/cc_carry.sv
module cc_carry #(
  parameter int NS = 4
) (
  input  logic          lsb_ce_n,
  input  logic [NS-1:0] tc_n,
  output logic [NS-1:0] ce_n
);

  genvar gi;
  generate
    for (gi = 0; gi < NS; gi++) begin : g_en
      if (gi == 0) begin : g_lsb
        assign ce_n[gi] = lsb_ce_n;
      end else if (gi == 1) begin : g_direct
        // second slice: lowest flag wired straight in
        assign ce_n[gi] = tc_n[0];
      end else begin : g_or
        assign ce_n[gi] = |tc_n[gi-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/cc_reload.sv
module cc_reload #(
  parameter int NS = 4
) (
  input  logic          load,
  input  logic          div_mode,
  input  logic [NS-1:0] tc_n,
  output logic [NS-1:0] pe,
  output logic          chain_tc_n,
  output logic          tc_reload
);

  // a true OR of every slice flag, never a wired tie
  assign chain_tc_n = |tc_n;
  assign tc_reload  = div_mode & ~chain_tc_n;

  genvar gi;
  generate
    for (gi = 0; gi < NS; gi++) begin : g_pe
      assign pe[gi] = load | tc_reload;
    end
  endgenerate

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int SLICE_W = cascade_counter_pkg::DEF_SLICE_W,
  parameter int SLICES  = cascade_counter_pkg::DEF_SLICES,
  localparam int WIDTH  = SLICE_W * SLICES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             div_mode,
  input  logic             load,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             chain_tc_n
);

  logic [SLICES-1:0] tc_n;
  logic [SLICES-1:0] ce_n;
  logic [SLICES-1:0] pe;
  logic              tc_reload;

  cc_carry #(.NS(SLICES)) u_carry (
    .lsb_ce_n (1'b0),
    .tc_n     (tc_n),
    .ce_n     (ce_n)
  );

  cc_reload #(.NS(SLICES)) u_reload (
    .load       (load),
    .div_mode   (div_mode),
    .tc_n       (tc_n),
    .pe         (pe),
    .chain_tc_n (chain_tc_n),
    .tc_reload  (tc_reload)
  );

  genvar gi;
  generate
    for (gi = 0; gi < SLICES; gi++) begin : g_slice
      cc_slice #(.SW(SLICE_W)) u_slice (
        .clk         (clk),
        .rst         (rst),
        .ce_n        (ce_n[gi]),
        .pe          (pe[gi]),
        .self_reload (1'b0),
        .p           (preset[gi*SLICE_W +: SLICE_W]),
        .q           (count[gi*SLICE_W +: SLICE_W]),
        .tc_n        (tc_n[gi])
      );
    end
  endgenerate

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |-> (count == '0 && chain_tc_n));                                  // R1
  AST_FREE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load && !tc_reload) |=> (count == $past(count) + 1'b1));             // R2
  AST_TC_FLAG: assert property (@(posedge clk) disable iff (rst)
    ((count == '1) == !chain_tc_n));                                       // R4
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(preset)));                                    // R8
  AST_DIV_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (div_mode && !chain_tc_n) |=> (count == $past(preset)));               // R6
  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && count[SLICE_W-1:0] != '1)
      |=> (count[WIDTH-1:SLICE_W] == $past(count[WIDTH-1:SLICE_W])));      // R3

endmodule

// File: tb/cascade_counter_bench.sv
module cascade_counter_bench;

  localparam int W = 32;
  localparam logic [W-1:0] ALL1 = '1;

  logic         clk = 1'b0;
  logic         rst;
  logic         div_mode;
  logic         load;
  logic [W-1:0] preset;
  logic [W-1:0] count;
  logic         chain_tc_n;

  int checks   = 0;
  int failures = 0;
  logic [W-1:0] ref_v;

  always #4 clk = ~clk;

  cascade_counter u_cascade_counter (
    .clk(clk), .rst(rst), .div_mode(div_mode), .load(load),
    .preset(preset), .count(count), .chain_tc_n(chain_tc_n)
  );

  task automatic chk(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_word(input logic [W-1:0] p);
    preset = p;
    load   = 1'b1;
    step();
    load   = 1'b0;
    ref_v  = p;
    chk(count == p, "R5 load", count, p);
  endtask

  // run n cycles against a wide reference; period > 0 also checks tc spacing
  task automatic run(input int n, input int period, input string tag);
    int last;
    last = -1;
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] prev;
      prev  = ref_v;
      ref_v = (div_mode && ref_v == ALL1) ? preset : ref_v + 1'b1;
      step();
      chk(count == ref_v, tag, count, ref_v);
      chk(chain_tc_n == (ref_v != ALL1), "R4 chain flag", {31'd0, chain_tc_n}, {31'd0, ref_v != ALL1});
      if (!div_mode && prev[7:0] != 8'hFF)
        chk(count[W-1:8] == prev[W-1:8], "R3 upper hold", count, prev);
      if (period > 0 && !chain_tc_n) begin
        if (last >= 0) chk((i - last) == period, "R6 period", W'(i - last), W'(period));
        last = i;
      end
    end
  endtask

  task automatic t_reset();
    chk(count == '0, "R1 reset count", count, '0);
    chk(chain_tc_n == 1'b1, "R1 reset flag", {31'd0, chain_tc_n}, 32'd1);
  endtask

  task automatic t_count();
    div_mode = 1'b0;
    load_word(32'hFFFF_FFF0);  run(40, 0, "R2 wrap");
    load_word(32'h00FF_FFF8);  run(20, 0, "R3 carry into slice 3");
    load_word(32'h0000_FFFC);  run(10, 0, "R3 carry into slice 2");
    load_word(32'h1234_56F0);  run(30, 0, "R2 plain count");
  endtask

  task automatic t_preset_ignored();
    div_mode = 1'b0;
    load_word(32'h0000_00F8);
    preset = 32'h5555_AAAA;
    run(5, 0, "R7 preset ignored");
    preset = 32'h0000_0000;
    run(12, 0, "R7 preset ignored");
  endtask

  task automatic t_divider(input int m);
    logic [W-1:0] p;
    div_mode = 1'b1;
    p = W'(33'h1_0000_0000 - 33'(m));
    load_word(p);
    run(3 * m + 3, m, "R6 divider");
    div_mode = 1'b0;
  endtask

  task automatic t_load_on_carry();
    div_mode = 1'b0;
    load_word(32'h00FF_FFFF);
    preset = 32'hABCD_0001;
    load   = 1'b1;
    step();
    load   = 1'b0;
    chk(count == 32'hABCD_0001, "R8 load beats carry", count, 32'hABCD_0001);
    // divider: new preset at terminal count replaces the old one
    div_mode = 1'b1;
    load_word(32'hFFFF_FFFE);
    step();
    chk(chain_tc_n == 1'b0, "R6 at top", {31'd0, chain_tc_n}, 32'd0);
    preset = 32'h0000_0100;
    load   = 1'b1;
    step();
    load   = 1'b0;
    chk(count == 32'h0000_0100, "R8 load at reload", count, 32'h0000_0100);
    div_mode = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; div_mode = 1'b0; load = 1'b0; preset = '0; ref_v = '0;
    repeat (3) @(negedge clk);
    chk(count == '0, "R1 in reset", count, '0);
    rst = 1'b0;
    t_reset();
    t_count();
    t_preset_ignored();
    t_divider(1);
    t_divider(2);
    t_divider(3);
    t_divider(113);
    t_divider(256);
    t_divider(257);
    t_divider(1000);
    t_divider(4097);
    t_load_on_carry();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule